// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This unit is the multiply-accumulate datapath of a processor execute stage. It receives two 32-bit operands and a 64-bit running sum split into a high word and a low word. It returns the updated 64-bit sum, again as a high word and a low word. A two-bit opcode picks the kind of product that is added to the sum:

- a full 32x32 signed product;
- one 16x16 signed product, with the halfword of each operand chosen by its own select bit;
- two 16x16 signed products, taken lane by lane;
- two 16x16 signed products with the halves of the second operand crossed over.

The result is captured one clock after an input strobe, and a matching output strobe goes with it. Register access, decode and flags are handled elsewhere. The unit produces no flags of any kind. The sum wraps modulo 2^64, with no saturation and no overflow indication.

Top module: `hmac_unit`

## Requirements
- R1: After reset, `res_valid` is 0 and `res_hi`/`res_lo` are all zero.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `in_valid`=1, and 0 after a cycle with `in_valid`=0.
- R3: A cycle with `in_valid`=0 leaves `res_hi`/`res_lo` unchanged on the next edge.
- R4: Opcode 0 adds the signed 32x32 product of `opnd_a` and `opnd_b` to the signed 64-bit value {`acc_hi`,`acc_lo`}.
- R5: Opcode 1 adds one signed 16x16 product. `sel_a`=1 takes bits 31:16 of `opnd_a` and `sel_a`=0 takes bits 15:0; `sel_b` makes the same choice for `opnd_b`. The product is sign-extended to 64 bits before it is added.
- R6: Opcode 2 adds a[31:16]*b[31:16] + a[15:0]*b[15:0], each halfword treated as signed.
- R7: Opcode 3 adds a[31:16]*b[15:0] + a[15:0]*b[31:16], each halfword treated as signed.
- R8: The two lane products are summed without loss. When both lanes compute -32768 * -32768, the sum added is +2^31.
- R9: The 64-bit sum wraps modulo 2^64. It is not saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| opcode | input | 2 | 0 full word, 1 single halfword, 2 dual, 3 dual crossed |
| sel_a | input | 1 | Single mode: 1 selects the top half of `opnd_a` |
| sel_b | input | 1 | Single mode: 1 selects the top half of `opnd_b` |
| opnd_a | input | 32 | First multiplicand |
| opnd_b | input | 32 | Second multiplicand |
| acc_hi | input | 32 | Upper word of the incoming 64-bit sum |
| acc_lo | input | 32 | Lower word of the incoming 64-bit sum |
| res_valid | output | 1 | Result words are fresh this cycle |
| res_hi | output | 32 | Upper word of the result |
| res_lo | output | 32 | Lower word of the result |

## Verification
Two behaviours can land in the same cycle: the widening of the two-lane product sum past 32 bits, and the carry of the 64-bit accumulation out of its top bit. The bench provokes both at once. It sets both lanes to -32768 * -32768 while the incoming sum sits just below a signed or unsigned boundary. It then checks the result words against a 64-bit reference computed in the bench. Back-to-back strobes are mixed with idle cycles, so that updates and holds alternate at random.

// File: rtl/hmac_unit.sv
module hmac_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   opcode,
  input  logic         sel_a,
  input  logic         sel_b,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] acc_hi,
  input  logic [W-1:0] acc_lo,
  output logic         res_valid,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int H = W / 2;
  localparam int D = 2 * W;

  localparam logic [1:0] OP_FULL  = 2'd0;
  localparam logic [1:0] OP_SINGLE = 2'd1;
  localparam logic [1:0] OP_DUAL  = 2'd2;
  localparam logic [1:0] OP_CROSS = 2'd3;

  logic signed [H-1:0] a_top, a_bot, b_top, b_bot;
  assign a_top = opnd_a[W-1:H];
  assign a_bot = opnd_a[H-1:0];
  assign b_top = opnd_b[W-1:H];
  assign b_bot = opnd_b[H-1:0];

  logic signed [H-1:0] l0_a, l0_b, l1_a, l1_b;
  always_comb begin
    l0_a = a_top;
    l0_b = b_top;
    l1_a = a_bot;
    l1_b = b_bot;
    unique case (opcode)
      OP_SINGLE: begin
        l0_a = sel_a ? a_top : a_bot;
        l0_b = sel_b ? b_top : b_bot;
        l1_a = '0;
        l1_b = '0;
      end
      OP_CROSS: begin
        l0_b = b_bot;
        l1_b = b_top;
      end
      default: ;
    endcase
  end

  logic signed [W-1:0] prod0, prod1;
  assign prod0 = W'(l0_a) * W'(l0_b);
  assign prod1 = W'(l1_a) * W'(l1_b);

  logic signed [W:0] lane_sum;
  assign lane_sum = (W+1)'(prod0) + (W+1)'(prod1);

  logic signed [W-1:0] fa, fb;
  logic signed [D-1:0] full_prod;
  assign fa = opnd_a;
  assign fb = opnd_b;
  assign full_prod = D'(fa) * D'(fb);

  logic [D-1:0] addend, acc_in, acc_next;
  assign addend   = (opcode == OP_FULL) ? full_prod : D'(lane_sum);
  assign acc_in   = {acc_hi, acc_lo};
  assign acc_next = acc_in + addend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hi    <= '0;
      res_lo    <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_hi <= acc_next[D-1:W];
        res_lo <= acc_next[W-1:0];
      end
    end
  end
endmodule

// File: rtl/hmac_unit_chk.sv
module hmac_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   opcode,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] acc_hi,
  input logic [W-1:0] acc_lo,
  input logic         res_valid,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo
);
  logic [2*W-1:0] wide_a, wide_b, full_ref;
  assign wide_a   = {{W{opnd_a[W-1]}}, opnd_a};
  assign wide_b   = {{W{opnd_b[W-1]}}, opnd_b};
  assign full_ref = {acc_hi, acc_lo} + wide_a * wide_b;

  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({res_hi, res_lo}));

  p_full_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'd0) |=> ({res_hi, res_lo} == $past(full_ref)));
endmodule

bind hmac_unit hmac_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
  .res_valid(res_valid), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/hmac_unit_tb_top.sv
`timescale 1ns/1ps
module hmac_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] opcode = '0;
  logic sel_a = 1'b0, sel_b = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, acc_hi = '0, acc_lo = '0;
  logic res_valid;
  logic [31:0] res_hi, res_lo;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hmac_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .res_valid(res_valid),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  function automatic logic [63:0] ref_mac(input logic [1:0] op, input logic sa, input logic sb,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [63:0] acc);
    longint at, ab, bt, bb, x, y, p;
    at = longint'($signed(a[31:16]));
    ab = longint'($signed(a[15:0]));
    bt = longint'($signed(b[31:16]));
    bb = longint'($signed(b[15:0]));
    case (op)
      2'd0: p = longint'($signed(a)) * longint'($signed(b));
      2'd1: begin
        x = sa ? at : ab;
        y = sb ? bt : bb;
        p = x * y;
      end
      2'd2: p = at * bt + ab * bb;
      default: p = at * bb + ab * bt;
    endcase
    return acc + 64'(p);
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [31:0] pick_word();
    case ($urandom % 6)
      0: return 32'h8000_8000;
      1: return 32'h7FFF_8000;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  logic [63:0] exp_res;
  logic exp_valid;
  string last_tag;

  task automatic issue(input logic [1:0] op, input logic sa, input logic sb,
                       input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc,
                       input string tag);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; sel_a = sa; sel_b = sb;
    opnd_a = a; opnd_b = b; {acc_hi, acc_lo} = acc;
    @(negedge clk);
    in_valid = 1'b0;
    check64(tag, {res_hi, res_lo}, ref_mac(op, sa, sb, a, b, acc));
    check64({tag, " valid"}, {63'd0, res_valid}, 64'd1);
  endtask

  initial begin
    int unsigned seed = 32'd20240601;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check64("R1 valid", {63'd0, res_valid}, 64'd0);
    check64("R1 data", {res_hi, res_lo}, 64'd0);
    rst_n = 1'b1;

    issue(2'd2, 0, 0, 32'h8000_8000, 32'h8000_8000, 64'd0, "R8");
    issue(2'd3, 0, 0, 32'h8000_8000, 32'h8000_8000, 64'd5, "R8 cross");
    issue(2'd2, 0, 0, 32'h8000_8000, 32'h8000_8000, 64'h7FFF_FFFF_FFFF_FFFF, "R9 R8");
    issue(2'd2, 0, 0, 32'h8000_8000, 32'h8000_8000, 64'hFFFF_FFFF_8000_0000, "R9 wrap");
    issue(2'd0, 0, 0, 32'h8000_0000, 32'h8000_0000, 64'hC000_0000_0000_0000, "R9 full");
    issue(2'd0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0003, 64'd10, "R4");
    issue(2'd1, 1, 0, 32'h8000_0002, 32'h0003_7FFF, 64'd0, "R5 top-bot");
    issue(2'd1, 0, 1, 32'h8000_0002, 32'hFFFD_7FFF, 64'd0, "R5 bot-top");
    issue(2'd1, 1, 1, 32'h8000_0002, 32'h8000_7FFF, 64'd1, "R5 top-top");
    issue(2'd3, 0, 0, 32'h0002_0005, 32'h0007_000B, 64'd0, "R7");
    issue(2'd2, 0, 0, 32'h0002_0005, 32'h0007_000B, 64'd0, "R6");

    @(negedge clk);
    check64("R2 idle valid", {63'd0, res_valid}, 64'd0);
    check64("R3 idle hold", {res_hi, res_lo}, ref_mac(2'd2, 0, 0, 32'h0002_0005, 32'h0007_000B, 64'd0));

    exp_res = {res_hi, res_lo};
    exp_valid = 1'b0;
    last_tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check64(last_tag, {res_hi, res_lo}, exp_res);
        check64("R2 strobe", {63'd0, res_valid}, {63'd0, exp_valid});
      end
      in_valid = ($urandom % 4) != 0;
      opcode = 2'($urandom);
      sel_a = 1'($urandom);
      sel_b = 1'($urandom);
      opnd_a = pick_word();
      opnd_b = pick_word();
      acc_hi = pick_word();
      acc_lo = pick_word();
      exp_valid = in_valid;
      if (in_valid) begin
        exp_res = ref_mac(opcode, sel_a, sel_b, opnd_a, opnd_b, {acc_hi, acc_lo});
        last_tag = op_tag(opcode);
      end else begin
        last_tag = "R3";
      end
    end
    @(negedge clk);
    check64(last_tag, {res_hi, res_lo}, exp_res);
    in_valid = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule